// File: doc/BRIEF.md
# Prescaled ADC Start-of-Conversion Trigger

This block sits beside a PWM time-base counter and turns its event strobes into a start-of-conversion request for an ADC. One of four counter events is picked by a 3-bit source selector: the counter reaching zero, the counter matching its period, or a compare match taken while counting up or while counting down. Each selected event that arrives is counted. When the count reaches a 2-bit prescale value, the block issues a single-cycle start pulse, raises a sticky flag and starts counting again from zero.

The running event count can be read on its own output, so software can see how far the block is into the current prescale window. For example, the period event with a prescale of one, on a timer counting up to 1999 from a 100 MHz clock, gives a 50 kHz conversion rate. An asynchronous active-low reset is taken in and released synchronously inside the block.

Top module: `etp_soc_trigger`

## Requirements
- R1: While reset is asserted, and after it has been released, soc_pulse and soc_flag are 0 and evt_count is 0.
- R2: src_sel 3'b001 selects evt_zero and 3'b010 selects evt_period. 3'b100 selects evt_cmp with cmp_up=1, and 3'b101 selects evt_cmp with cmp_up=0. Codes 000, 011, 110 and 111 select no event.
- R3: With div_sel = N (1 to 3) and trig_en=1, the Nth qualifying event sampled at a clock edge causes soc_pulse to be 1 for the cycle after that edge, and evt_count returns to 0 at that same edge.
- R4: evt_count shows the number of qualifying events counted since the last wrap. It increments at the edge that samples each event.
- R5: div_sel 2'b00 disables the trigger. No pulse is produced, the flag is not set, and evt_count is cleared to 0 at the next edge.
- R6: With trig_en=0 no pulse is produced and the flag is not set. Events are still counted, and the count wraps to 0 on reaching the prescale value.
- R7: soc_flag is set at the edge that produces a pulse and stays 1 until flag_clr is 1 at an edge. If a pulse and a clear occur at the same edge, the flag is set.
- R8: If div_sel is lowered to or below the current evt_count, the next qualifying event fires and wraps the count.
- R9: Strobes that the selector does not pick leave evt_count and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_zero | input | 1 | Counter-equals-zero strobe |
| evt_period | input | 1 | Counter-equals-period strobe |
| evt_cmp | input | 1 | Compare-match strobe |
| cmp_up | input | 1 | Count direction at the compare match (1 = up) |
| trig_en | input | 1 | Start pulse enable |
| src_sel | input | 3 | Event source selector |
| div_sel | input | 2 | Prescale: events per pulse, 0 = off |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| soc_pulse | output | 1 | Single-cycle start-of-conversion pulse |
| soc_flag | output | 1 | Sticky trigger flag |
| evt_count | output | 2 | Events counted in the current window |

## Verification
The hardest case to reach is a prescale value that drops below a count already accumulated. This only happens when div_sel is rewritten partway through a window. The stimulus first builds the count up to two under a prescale of three, then lowers the prescale to one during a cycle with no event, and then sends a single event. The same table also places a pulse and a flag clear on the same edge, and lets the count wrap while the pulse is disabled, to show that the flag stays low.

// File: rtl/etp_pkg.sv
package etp_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE0  = 3'b000,
    SRC_ZERO   = 3'b001,
    SRC_PERIOD = 3'b010,
    SRC_NONE3  = 3'b011,
    SRC_CMP_UP = 3'b100,
    SRC_CMP_DN = 3'b101,
    SRC_NONE6  = 3'b110,
    SRC_NONE7  = 3'b111
  } src_e;
endpackage

// File: rtl/etp_rst_sync.sv
module etp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/etp_src_mux.sv
module etp_src_mux
  import etp_pkg::*;
(
  input  logic             evt_zero,
  input  logic             evt_period,
  input  logic             evt_cmp,
  input  logic             cmp_up,
  input  logic [SEL_W-1:0] src_sel,
  output logic             qual_evt
);
  always_comb begin
    unique case (src_e'(src_sel))
      SRC_ZERO:   qual_evt = evt_zero;
      SRC_PERIOD: qual_evt = evt_period;
      SRC_CMP_UP: qual_evt = evt_cmp & cmp_up;
      SRC_CMP_DN: qual_evt = evt_cmp & ~cmp_up;
      default:    qual_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/etp_div_counter.sv
module etp_div_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual_evt,
  input  logic             trig_en,
  input  logic [CNT_W-1:0] div_sel,
  output logic             hit,
  output logic             soc_pulse,
  output logic [CNT_W-1:0] evt_count
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             pulse_q;
  logic             div_off;
  logic [EXT_W-1:0] cnt_inc;

  assign div_off = (div_sel == '0);
  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign cnt_ce  = div_off | qual_evt;

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (div_off) begin
      cnt_d = '0;
    end else if (qual_evt) begin
      if (cnt_inc >= {1'b0, div_sel}) begin
        cnt_d = '0;
        hit   = trig_en;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= hit;
  end

  assign soc_pulse = pulse_q;
  assign evt_count = cnt_q;

  AST_NO_PULSE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |=> !soc_pulse); // R6
  AST_DIV_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == '0) |=> (!soc_pulse && evt_count == '0)); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual_evt && div_sel != '0) |=> $stable(evt_count)); // R9
  AST_WRAP_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    soc_pulse |-> (evt_count == '0)); // R3
endmodule

// File: rtl/etp_flag.sv
module etp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_ce;

  assign flag_ce = set_i | clr_i;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R7
endmodule

// File: rtl/etp_soc_trigger.sv
module etp_soc_trigger
  import etp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_zero,
  input  logic             evt_period,
  input  logic             evt_cmp,
  input  logic             cmp_up,
  input  logic             trig_en,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [CNT_W-1:0] div_sel,
  input  logic             flag_clr,
  output logic             soc_pulse,
  output logic             soc_flag,
  output logic [CNT_W-1:0] evt_count
);
  logic rst_sync_n;
  logic qual_evt;
  logic hit;

  etp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  etp_src_mux u_mux (
    .evt_zero   (evt_zero),
    .evt_period (evt_period),
    .evt_cmp    (evt_cmp),
    .cmp_up     (cmp_up),
    .src_sel    (src_sel),
    .qual_evt   (qual_evt)
  );

  etp_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .qual_evt  (qual_evt),
    .trig_en   (trig_en),
    .div_sel   (div_sel),
    .hit       (hit),
    .soc_pulse (soc_pulse),
    .evt_count (evt_count)
  );

  etp_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (hit),
    .clr_i  (flag_clr),
    .flag_o (soc_flag)
  );

  AST_PULSE_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soc_pulse |-> soc_flag); // R3
endmodule

// File: tb/etp_soc_trigger_bench.sv
module etp_soc_trigger_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_zero, evt_period, evt_cmp, cmp_up, trig_en, flag_clr;
  logic [2:0] src_sel;
  logic [1:0] div_sel;
  logic       soc_pulse, soc_flag;
  logic [1:0] evt_count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  etp_soc_trigger u_etp_soc_trigger (
    .clk(clk), .rst_n(rst_n), .evt_zero(evt_zero), .evt_period(evt_period),
    .evt_cmp(evt_cmp), .cmp_up(cmp_up), .trig_en(trig_en), .src_sel(src_sel),
    .div_sel(div_sel), .flag_clr(flag_clr), .soc_pulse(soc_pulse),
    .soc_flag(soc_flag), .evt_count(evt_count)
  );

  // vector: sel[14:12] div[11:10] en[9] z[8] p[7] c[6] up[5] clr[4] | pulse[3] flag[2] cnt[1:0]
  localparam int NV = 27;
  localparam logic [14:0] VEC [NV] = '{
    {3'd2,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd0},
    {3'd2,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,2'd0},
    {3'd2,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,2'd0},
    {3'd2,2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd1},
    {3'd2,2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd2},
    {3'd2,2'd3,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd2},
    {3'd2,2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd0},
    {3'd2,2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,2'd0},
    {3'd1,2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd1},
    {3'd1,2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd0},
    {3'd4,2'd1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0,2'd0},
    {3'd4,2'd1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b1,2'd0},
    {3'd5,2'd1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b1,2'd0},
    {3'd3,2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,2'd0},
    {3'd0,2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,2'd0},
    {3'd6,2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,2'd0},
    {3'd7,2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0},
    {3'd2,2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0},
    {3'd2,2'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd1},
    {3'd2,2'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd2},
    {3'd2,2'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0},
    {3'd2,2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd1},
    {3'd2,2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd2},
    {3'd2,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd2},
    {3'd2,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd0},
    {3'd2,2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,2'd1},
    {3'd2,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0}
  };
  // requirement tag per row
  string TAGS [NV] = '{
    "R3","R3","R7","R4","R4","R9","R3","R7","R2","R2","R2","R2","R7","R2",
    "R2","R2","R2","R5","R6","R6","R6","R4","R4","R9","R8","R7","R5"
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pulse/flag/cnt actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [14:0] v);
    src_sel = v[14:12]; div_sel = v[11:10]; trig_en = v[9];
    evt_zero = v[8]; evt_period = v[7]; evt_cmp = v[6]; cmp_up = v[5]; flag_clr = v[4];
  endtask

  task automatic step(input logic [14:0] v, input string tag);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
    check(tag, {soc_pulse, soc_flag, evt_count}, v[3:0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(15'd0);
    #12;
    check("R1", {soc_pulse, soc_flag, evt_count}, 4'b0000); // R1 during reset
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {soc_pulse, soc_flag, evt_count}, 4'b0000); // R1 after release

    for (int i = 0; i < NV; i++) step(VEC[i], TAGS[i]);

    // directed: pulse then partial count, then mid-run reset (R1)
    step({3'd2,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd0}, "R3");
    step({3'd2,2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,2'd1}, "R4");
    step({3'd2,2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,2'd2}, "R4");
    @(negedge clk);
    drive(15'd0);
    rst_n = 1'b0;
    #1;
    check("R1", {soc_pulse, soc_flag, evt_count}, 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {soc_pulse, soc_flag, evt_count}, 4'b0000);

    // directed: a single event with prescale 2 leaves count 1, no pulse (R3)
    step({3'd1,2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd1}, "R3");
    step({3'd1,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd1}, "R3");

    finish_run();
  end
endmodule